// File: doc/BRIEF.md
# UART Receive Character Queue with Line Status

This block sits between a UART receiver and the host. Each time the receiver finishes assembling a character, it hands over the 8-bit data together with that character's own parity, framing and break flags. The block stores the data and flags side by side in a 16-entry queue. The host drains the queue one character at a time and reads an 8-bit line status word. The status word shows data ready, a sticky overrun, the error flags of the character at the head, transmitter idle conditions, and a summary bit that is set while any stored character is in error.

A receive-data interrupt is raised while the fill level is at or above a programmable trigger level. This happens only when both the queue enable and the receive interrupt enable are set. When both enables are not set, the host polls the status word instead.

Both data paths use valid/ready handshakes. On the receive side, `in_ready` is low while the queue is full. The serial receiver cannot stall, so a character presented while `in_ready` is low is discarded and recorded as an overrun. On the host side, `out_valid` is high while the queue holds a character, and a character is removed on a clock edge where both `out_valid` and `out_ready` are high. Presenting `out_ready` to an empty queue has no effect.

Top module: `rx_fifo_status`

## Requirements
- R1: After reset the queue is empty: `out_valid`=0, `in_ready`=1, `rx_irq`=0, and status bits 0-4 and 7 are 0.
- R2: Status bit 0 is 1 from the clock edge that accepts a character until the edge that removes the last stored character.
- R3: `rx_irq` is 1 while the fill count is at or above the trigger level selected by `trig_sel`, and 0 as soon as it falls below. The codes are 0→1, 1→4, 2→8 and 3→14 entries.
- R4: `rx_irq` is 0 unless both `fifo_en` and `rx_irq_en` are 1. In polled mode (`fifo_en`=1, `rx_irq_en`=0) the status bits keep working.
- R5: Characters leave the queue in arrival order, with their data unchanged.
- R6: A character presented while the queue holds 16 entries is discarded, the stored contents are kept, and status bit 1 (overrun) is set at that edge.
- R7: The overrun bit stays set until a `lsr_rd` pulse, and it reads 0 after the edge that samples `lsr_rd`. A new overrun in the same cycle as `lsr_rd` wins.
- R8: Status bits 2, 3 and 4 are the parity, framing and break flags (`in_err` bits 0, 1 and 2) of the character at the head. They are 0 when the queue is empty.
- R9: Status bit 7 is 1 while at least one stored character has any error flag set. It returns to 0 once the last such character is removed.
- R10: Status bit 5 equals `tx_fifo_empty`. Status bit 6 is 1 only when both `tx_fifo_empty` and `tx_shift_empty` are 1.
- R11: A `fifo_clr` pulse empties the queue and clears status bits 0-4 and 7 at the next edge, and it takes precedence over a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_clr | input | 1 | Synchronous queue clear |
| in_valid | input | 1 | Receiver presents a character |
| in_ready | output | 1 | Queue has room for a character |
| in_data | input | 8 | Received character |
| in_err | input | 3 | Character flags: bit0 parity, bit1 framing, bit2 break |
| out_valid | output | 1 | Head character is available |
| out_ready | input | 1 | Host removes the head character |
| out_data | output | 8 | Head character |
| lsr_rd | input | 1 | Host reads the status word (clears overrun) |
| fifo_en | input | 1 | Queue enable, gates the interrupt |
| rx_irq_en | input | 1 | Receive-data interrupt enable |
| trig_sel | input | 2 | Trigger level code |
| tx_fifo_empty | input | 1 | Transmit queue empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| lsr | output | 8 | Line status word |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
The bench builds the block with its default values: 8-bit data and a depth of 16. With these values the highest trigger code (14 entries) and the full-queue overrun case are both reached within a few dozen pushes. A scoreboard queue predicts each character and its flags at the head. This lets the bench check the per-character error bits and the error summary as mixed clean and flagged characters drain.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Per-character flags, bit order matches status bits 2..4
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  // Trigger level for a 2-bit code, scaled from the queue depth
  function automatic int trig_level(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  rx_err_t       wr_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output rx_err_t       rd_err,
  output logic [CW-1:0] count,
  output logic          err_any,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0]    mem_d [DEPTH];
  rx_err_t          mem_e [DEPTH];
  logic [DEPTH-1:0] bad_q;
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en && !full && !clr;
  assign rd_ok = rd_en && !empty && !clr;

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_d[wp_q] <= wr_data;
      mem_e[wp_q] <= wr_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= ptr_inc(wp_q);
      if (rd_ok) rp_q <= ptr_inc(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // One "holds an error" flag per slot, cleared when the slot is popped
  for (genvar g = 0; g < DEPTH; g++) begin : g_bad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bad_q[g] <= 1'b0;
      else if (clr)                              bad_q[g] <= 1'b0;
      else if (wr_ok && wp_q == AW'(g))          bad_q[g] <= |wr_err;
      else if (rd_ok && rp_q == AW'(g))          bad_q[g] <= 1'b0;
    end
  end

  assign err_any = |bad_q;
  assign rd_data = mem_d[rp_q];
  assign rd_err  = mem_e[rp_q];
  assign count   = cnt_q;

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_drop_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !clr) |=> (cnt_q == $past(cnt_q)));
  p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !err_any));

endmodule

// File: rtl/rxf_irq.sv
module rxf_irq
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_en,
  input  logic          irq_en,
  output logic          irq
);

  localparam logic [CW-1:0] LVL0 = CW'(trig_level(2'd0, DEPTH));
  localparam logic [CW-1:0] LVL1 = CW'(trig_level(2'd1, DEPTH));
  localparam logic [CW-1:0] LVL2 = CW'(trig_level(2'd2, DEPTH));
  localparam logic [CW-1:0] LVL3 = CW'(trig_level(2'd3, DEPTH));

  logic [CW-1:0] thr;
  logic          at_level;

  always_comb begin
    case (trig_sel)
      2'd0:    thr = LVL0;
      2'd1:    thr = LVL1;
      2'd2:    thr = LVL2;
      default: thr = LVL3;
    endcase
  end

  assign at_level = (count >= thr);
  assign irq      = fifo_en && irq_en && at_level;

  p_irq_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count != '0));

endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    ovr_evt,
  input  logic    lsr_rd,
  input  logic    not_empty,
  input  rx_err_t head_err,
  input  logic    err_any,
  input  logic    tx_fifo_empty,
  input  logic    tx_shift_empty,
  output logic [7:0] lsr
);

  logic    ovr_q;
  rx_err_t head_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (clr)     ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (lsr_rd)  ovr_q <= 1'b0;
  end

  assign head_vis = not_empty ? head_err : '0;

  assign lsr = {err_any,
                tx_fifo_empty && tx_shift_empty,
                tx_fifo_empty,
                head_vis.brk, head_vis.ferr, head_vis.perr,
                ovr_q,
                not_empty};

  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clr) |=> ovr_q);
  p_ovr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !lsr_rd && !clr) |=> ovr_q);

endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
  import rxf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [2:0]    in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic          lsr_rd,
  input  logic          fifo_en,
  input  logic          rx_irq_en,
  input  logic [1:0]    trig_sel,
  input  logic          tx_fifo_empty,
  input  logic          tx_shift_empty,
  output logic [7:0]    lsr,
  output logic          rx_irq
);

  logic [CW-1:0] count;
  logic          full, empty, err_any;
  rx_err_t       head_err;

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .wr_err  (rx_err_t'(in_err)),
    .rd_en   (out_ready),
    .rd_data (out_data),
    .rd_err  (head_err),
    .count   (count),
    .err_any (err_any),
    .full    (full),
    .empty   (empty)
  );

  rxf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .trig_sel (trig_sel),
    .fifo_en  (fifo_en),
    .irq_en   (rx_irq_en),
    .irq      (rx_irq)
  );

  rxf_status u_status (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr            (fifo_clr),
    .ovr_evt        (in_valid && full),
    .lsr_rd         (lsr_rd),
    .not_empty      (!empty),
    .head_err       (head_err),
    .err_any        (err_any),
    .tx_fifo_empty  (tx_fifo_empty),
    .tx_shift_empty (tx_shift_empty),
    .lsr            (lsr)
  );

  assign in_ready  = !full;
  assign out_valid = !empty;

  p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_en && rx_irq_en) |-> !rx_irq);
  p_err_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|lsr[4:2]) |-> lsr[7]);
  p_ready_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !fifo_clr) |=> lsr[0]);

endmodule

// File: tb/sim_rx_fifo_status.sv
module sim_rx_fifo_status;

  typedef struct packed {
    logic [7:0] d;
    logic [2:0] e;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_clr = 1'b0, in_valid = 1'b0, out_ready = 1'b0, lsr_rd = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] in_err = '0;
  logic       fifo_en = 1'b0, rx_irq_en = 1'b0;
  logic [1:0] trig_sel = '0;
  logic       tx_fifo_empty = 1'b1, tx_shift_empty = 1'b1;
  logic       in_ready, out_valid, rx_irq;
  logic [7:0] out_data, lsr;

  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  item_t q[$];

  always #5 clk = ~clk;

  rx_fifo_status u0 (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .lsr_rd(lsr_rd), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en), .trig_sel(trig_sel),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
    .lsr(lsr), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: offers one character; the scoreboard records it if accepted
  task automatic push(input logic [7:0] d, input logic [2:0] e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_err = e;
    if (in_ready) q.push_back('{d: d, e: e});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: compares the head against the scoreboard, then removes it
  task automatic pop_chk(input string tag);
    item_t exp;
    chk({tag, " out_valid"}, 32'(out_valid), 32'(q.size() != 0));
    if (q.size() != 0) begin
      exp = q.pop_front();
      chk({tag, " data"}, 32'(out_data), 32'(exp.d));
      chk({tag, " head flags"}, 32'(lsr[4:2]), 32'(exp.e));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic status_read();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lsr", 32'(lsr), 32'h60);
    chk("R1 irq", 32'(rx_irq), 0);
    chk("R1 in_ready", 32'(in_ready), 1);
    chk("R1 out_valid", 32'(out_valid), 0);

    fifo_en = 1'b1; rx_irq_en = 1'b1; trig_sel = 2'd0;
    push(8'hA5, 3'b000);
    chk("R2 data ready set", 32'(lsr[0]), 1);
    chk("R3 irq at level 1", 32'(rx_irq), 1);
    fifo_en = 1'b0; #1;
    chk("R4 irq gated by fifo_en", 32'(rx_irq), 0);
    fifo_en = 1'b1; rx_irq_en = 1'b0; #1;
    chk("R4 polled irq off", 32'(rx_irq), 0);
    chk("R4 polled data ready", 32'(lsr[0]), 1);
    rx_irq_en = 1'b1;
    pop_chk("R5 single");
    chk("R2 data ready clear", 32'(lsr[0]), 0);
    chk("R3 irq below level", 32'(rx_irq), 0);

    // R3 highest trigger code
    trig_sel = 2'd3;
    for (int i = 0; i < 13; i++) push(8'h10 + 8'(i), 3'b000);
    chk("R3 13 below 14", 32'(rx_irq), 0);
    push(8'h1D, 3'b000);
    chk("R3 14 reaches 14", 32'(rx_irq), 1);
    pop_chk("R5 after trig");
    chk("R3 drops below 14", 32'(rx_irq), 0);

    // R6/R7 overrun
    for (int i = 0; i < 3; i++) push(8'h40 + 8'(i), 3'b000);
    chk("R6 full not ready", 32'(in_ready), 0);
    chk("R6 no overrun yet", 32'(lsr[1]), 0);
    push(8'hEE, 3'b111);
    chk("R6 overrun set", 32'(lsr[1]), 1);
    chk("R6 no flags from dropped", 32'(lsr[7]), 0);
    @(negedge clk);
    chk("R7 overrun sticky", 32'(lsr[1]), 1);
    status_read();
    chk("R7 overrun cleared by read", 32'(lsr[1]), 0);
    while (q.size() != 0) pop_chk("R5 drain");
    chk("R6 dropped char absent", 32'(out_valid), 0);

    // R8/R9 per-character flags and summary
    push(8'h11, 3'b000);
    push(8'h22, 3'b001);
    push(8'h33, 3'b000);
    push(8'h44, 3'b100);
    chk("R8 clean head", 32'(lsr[4:2]), 0);
    chk("R9 summary set", 32'(lsr[7]), 1);
    pop_chk("R5 e1");
    chk("R8 parity head", 32'(lsr[4:2]), 3'b001);
    pop_chk("R5 e2");
    chk("R9 summary holds", 32'(lsr[7]), 1);
    pop_chk("R5 e3");
    chk("R8 break head", 32'(lsr[4:2]), 3'b100);
    pop_chk("R5 e4");
    chk("R9 summary clears", 32'(lsr[7]), 0);
    chk("R8 empty flags zero", 32'(lsr[4:2]), 0);
    push(8'h55, 3'b010);
    chk("R8 framing head", 32'(lsr[4:2]), 3'b010);
    pop_chk("R5 e5");

    // R10 transmit pass-through
    tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0; #1;
    chk("R10 fifo only", 32'(lsr[6:5]), 2'b01);
    tx_fifo_empty = 1'b0; tx_shift_empty = 1'b1; #1;
    chk("R10 shift only", 32'(lsr[6:5]), 2'b00);
    tx_fifo_empty = 1'b1; #1;
    chk("R10 both", 32'(lsr[6:5]), 2'b11);

    // R11 clear with concurrent push
    trig_sel = 2'd0;
    push(8'h66, 3'b010);
    push(8'h77, 3'b001);
    @(negedge clk);
    fifo_clr = 1'b1; in_valid = 1'b1; in_data = 8'h99; in_err = 3'b100;
    @(negedge clk);
    fifo_clr = 1'b0; in_valid = 1'b0;
    q.delete();
    chk("R11 lsr cleared", 32'(lsr), 32'h60);
    chk("R11 empty", 32'(out_valid), 0);
    chk("R11 irq off", 32'(rx_irq), 0);
    push(8'h5A, 3'b000);
    pop_chk("R11 usable after clear");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule